// File: doc/BRIEF.md
# Power-State Control Output Selector

This block drives a pair of active-low control outputs to programmable levels according to the power condition the system is in: S3 sleep, S5 soft-off, or the period after AC power has been lost. A six-bit level register holds one level bit per output per condition. A 0 bit drives that output low in that condition, and a 1 bit drives it high. When the system is working, both outputs rest high (inactive). The block also keeps a sticky resume flag. The flag is raised when the system comes back from S3 to the working state, and software clears it by writing a 1 to it.

The power condition itself comes from elsewhere as a two-bit state code and an AC-loss line. Only the battery-backed reset initialises the register and the flag, so the settings survive ordinary system resets. A small write port, with a select between the level register and the status register, programs the block. A read port returns either register.

Top module: `psc_ctl_sel`

## Requirements
- R1: With `ac_lost` low and `pwr_state` = 2'b01 (S3), `ctl_n[1]` takes level bit 5 and `ctl_n[0]` takes level bit 4.
- R2: With `ac_lost` low and `pwr_state` = 2'b10 (S5), `ctl_n[1]` takes level bit 3 and `ctl_n[0]` takes level bit 2.
- R3: With `ac_lost` high, `ctl_n[1]` takes level bit 1 and `ctl_n[0]` takes level bit 0, whatever `pwr_state` says (this includes S5 and S3).
- R4: With `ac_lost` low and `pwr_state` = 2'b00 (working) or 2'b11 (unused code), both outputs are high.
- R5: After the battery-backed reset, the level register reads 6'b001100, the resume flag is 0 and both outputs are high.
- R6: The resume flag becomes 1 at the clock edge where `pwr_state` is 2'b00 and the previous sampled state was 2'b01. A move from S3 to S5 does not set it.
- R7: A write with `wr_sel` = 1 and `wr_data[0]` = 1 clears the flag. Any other write leaves the flag unchanged. If the flag is set and cleared at the same edge, setting wins.
- R8: A write with `wr_sel` = 0 loads `wr_data[5:0]` into the level register. Bits 7:6 are ignored and always read 0. A read with `rd_sel` = 1 returns the flag in bit 0 and 0 in bits 7:1.
- R9: `ctl_n` and the flag are registered and change at the first clock edge after their inputs change. A level-register write takes effect on `ctl_n` at the edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| vbat_rst_n | input | 1 | Battery-backed asynchronous reset, active low |
| pwr_state | input | 2 | 00 working, 01 S3, 10 S5, 11 treated as working |
| ac_lost | input | 1 | High while in the after-AC-loss condition |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 level register, 1 status register |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 level register, 1 status register |
| rd_data | output | 8 | Read data, combinational |
| ctl_n | output | 2 | Active-low control outputs |
| resume_flag | output | 1 | Sticky return-from-S3 flag |

## Verification
A change of state code or AC-loss line shows on `ctl_n` one edge later. The flag settles on the edge where the working code follows S3. A level-register write is visible on `rd_data` right after its own edge and on `ctl_n` one edge after that. The driver applies stimulus on the falling edge. It then queues the expected values for the next rising edge, which its reference model derives from the requirements. The monitor compares them 2 ns after that edge, once all registers have settled.

// File: rtl/psc_pkg.sv
package psc_pkg;
   typedef enum logic [1:0] {
      PS_WORK = 2'b00,
      PS_S3   = 2'b01,
      PS_S5   = 2'b10,
      PS_RSVD = 2'b11
   } pstate_e;

   // condition slots, lowest index has highest priority
   localparam int COND_N  = 3;
   localparam int COND_AC = 0;
   localparam int COND_S5 = 1;
   localparam int COND_S3 = 2;
endpackage

// File: rtl/psc_cond_decode.sv
module psc_cond_decode
   import psc_pkg::*;
(
   input  logic [1:0]        pwr_state,
   input  logic              ac_lost,
   output logic [COND_N-1:0] cond_hit
);
   always_comb begin
      cond_hit          = '0;
      cond_hit[COND_AC] = ac_lost;
      cond_hit[COND_S5] = !ac_lost && (pwr_state == PS_S5);
      cond_hit[COND_S3] = !ac_lost && (pwr_state == PS_S3);
   end
endmodule

// File: rtl/psc_level_mux.sv
module psc_level_mux #(
   parameter int COND_N = 3
) (
   input  logic [COND_N-1:0] cond_hit,
   input  logic [COND_N-1:0] lvl_cfg,
   output logic              lvl
);
   // no active condition: output rests high (inactive)
   always_comb lvl = (|cond_hit) ? (|(cond_hit & lvl_cfg)) : 1'b1;
endmodule

// File: rtl/psc_cfg_reg.sv
module psc_cfg_reg #(
   parameter int               CFG_W   = 6,
   parameter logic [CFG_W-1:0] CFG_RST = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] cfg_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg_q <= CFG_RST;
      else if (we) cfg_q <= wdata;
   end
endmodule

// File: rtl/psc_resume_flag.sv
module psc_resume_flag
   import psc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] pwr_state,
   input  logic       clr,
   output logic       flag
);
   logic [1:0] prev_q;
   logic       set_now;

   always_comb set_now = (prev_q == PS_S3) && (pwr_state == PS_WORK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= PS_WORK;
         flag   <= 1'b0;
      end else begin
         prev_q <= pwr_state;
         if (set_now)  flag <= 1'b1;
         else if (clr) flag <= 1'b0;
      end
   end
endmodule

// File: rtl/psc_ctl_sel.sv
module psc_ctl_sel
   import psc_pkg::*;
#(
   parameter int                         NUM_OUT = 2,
   parameter int                         DATA_W  = 8,
   parameter bit                         REG_OUT = 1'b1,
   parameter logic [COND_N*NUM_OUT-1:0]  CFG_RST = 'b001100
) (
   input  logic              clk,
   input  logic              vbat_rst_n,
   input  logic [1:0]        pwr_state,
   input  logic              ac_lost,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic [NUM_OUT-1:0] ctl_n,
   output logic              resume_flag
);
   localparam int CFG_W = COND_N * NUM_OUT;

   if (DATA_W < CFG_W) begin : g_bad_width
      $error("psc_ctl_sel: DATA_W must hold all level bits");
   end
   if (NUM_OUT < 1) begin : g_bad_count
      $error("psc_ctl_sel: NUM_OUT must be at least 1");
   end

   logic [CFG_W-1:0]  cfg_q;
   logic [COND_N-1:0] cond_hit;
   logic              cfg_we;
   logic              flag_clr;
   logic              unused_hi;

   assign cfg_we    = wr_en && !wr_sel;
   assign flag_clr  = wr_en && wr_sel && wr_data[0];
   assign unused_hi = &{1'b0, wr_data[DATA_W-1:CFG_W]};

   psc_cfg_reg #(.CFG_W(CFG_W), .CFG_RST(CFG_RST)) u_cfg (
      .clk   (clk),
      .rst_n (vbat_rst_n),
      .we    (cfg_we),
      .wdata (wr_data[CFG_W-1:0]),
      .cfg_q (cfg_q)
   );

   psc_cond_decode u_dec (
      .pwr_state (pwr_state),
      .ac_lost   (ac_lost),
      .cond_hit  (cond_hit)
   );

   psc_resume_flag u_flag (
      .clk       (clk),
      .rst_n     (vbat_rst_n),
      .pwr_state (pwr_state),
      .clr       (flag_clr),
      .flag      (resume_flag)
   );

   for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_out
      logic lvl_d;
      psc_level_mux #(.COND_N(COND_N)) u_mux (
         .cond_hit (cond_hit),
         .lvl_cfg  ({cfg_q[COND_S3*NUM_OUT+gi],
                     cfg_q[COND_S5*NUM_OUT+gi],
                     cfg_q[COND_AC*NUM_OUT+gi]}),
         .lvl      (lvl_d)
      );
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge vbat_rst_n) begin
            if (!vbat_rst_n) ctl_n[gi] <= 1'b1;
            else             ctl_n[gi] <= lvl_d;
         end
      end else begin : g_comb
         assign ctl_n[gi] = lvl_d;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_sel) rd_data[0]         = resume_flag;
      else        rd_data[CFG_W-1:0] = cfg_q;
   end
endmodule

// File: rtl/psc_ctl_sel_chk.sv
module psc_ctl_sel_chk
   import psc_pkg::*;
#(
   parameter int NUM_OUT = 2,
   parameter bit REG_OUT = 1'b1
) (
   input logic                      clk,
   input logic                      vbat_rst_n,
   input logic [1:0]                pwr_state,
   input logic                      ac_lost,
   input logic                      wr_en,
   input logic                      wr_sel,
   input logic [7:0]                wr_data,
   input logic [COND_N*NUM_OUT-1:0] cfg_q,
   input logic [NUM_OUT-1:0]        ctl_n,
   input logic                      resume_flag
);
   if (REG_OUT) begin : g_reg_checks
      // R1
      p_s3_level_r1: assert property (@(posedge clk) disable iff (!vbat_rst_n)
         (!ac_lost && pwr_state == PS_S3) |=> ctl_n == $past(cfg_q[COND_S3*NUM_OUT +: NUM_OUT]));
      // R2
      p_s5_level_r2: assert property (@(posedge clk) disable iff (!vbat_rst_n)
         (!ac_lost && pwr_state == PS_S5) |=> ctl_n == $past(cfg_q[COND_S5*NUM_OUT +: NUM_OUT]));
      // R3
      p_ac_prio_r3: assert property (@(posedge clk) disable iff (!vbat_rst_n)
         ac_lost |=> ctl_n == $past(cfg_q[COND_AC*NUM_OUT +: NUM_OUT]));
      // R4
      p_work_high_r4: assert property (@(posedge clk) disable iff (!vbat_rst_n)
         (!ac_lost && (pwr_state == PS_WORK || pwr_state == PS_RSVD)) |=> &ctl_n);
   end

   // R6
   p_flag_set_r6: assert property (@(posedge clk) disable iff (!vbat_rst_n)
      (pwr_state == PS_S3 ##1 pwr_state == PS_WORK) |=> resume_flag);
   // R7: only a clearing write may drop the flag
   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!vbat_rst_n)
      (resume_flag && !(wr_en && wr_sel && wr_data[0])) |=> resume_flag);
   // R7: a clearing write with no return in progress drops it
   p_flag_clear_r7: assert property (@(posedge clk) disable iff (!vbat_rst_n)
      (wr_en && wr_sel && wr_data[0] && pwr_state != PS_WORK) |=> !resume_flag);
   // R6: the flag only rises on the working state
   p_flag_rise_r6: assert property (@(posedge clk) disable iff (!vbat_rst_n)
      $rose(resume_flag) |-> $past(pwr_state) == PS_WORK);
endmodule

bind psc_ctl_sel psc_ctl_sel_chk #(.NUM_OUT(NUM_OUT), .REG_OUT(REG_OUT)) u_chk (
   .clk         (clk),
   .vbat_rst_n  (vbat_rst_n),
   .pwr_state   (pwr_state),
   .ac_lost     (ac_lost),
   .wr_en       (wr_en),
   .wr_sel      (wr_sel),
   .wr_data     (wr_data),
   .cfg_q       (cfg_q),
   .ctl_n       (ctl_n),
   .resume_flag (resume_flag)
);

// File: tb/tb_psc_ctl_sel.sv
module tb_psc_ctl_sel;
   logic       clk = 1'b0;
   logic       vbat_rst_n = 1'b0;
   logic [1:0] pwr_state = 2'b00;
   logic       ac_lost = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_sel = 1'b0;
   logic [7:0] rd_data;
   logic [1:0] ctl_n;
   logic       resume_flag;

   int n_chk  = 0;
   int n_fail = 0;

   typedef struct {
      logic [1:0] ctl;
      logic       flag;
      logic [7:0] rd;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   // reference model state
   logic [5:0] m_cfg  = 6'b001100;
   logic       m_flag = 1'b0;
   logic [1:0] m_prev = 2'b00;

   always #4 clk = ~clk;

   psc_ctl_sel dut (
      .clk(clk), .vbat_rst_n(vbat_rst_n), .pwr_state(pwr_state), .ac_lost(ac_lost),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
      .rd_data(rd_data), .ctl_n(ctl_n), .resume_flag(resume_flag)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] lvl_of(input logic [5:0] c, input logic [1:0] st, input logic ac);
      if (ac)              return c[1:0];
      else if (st == 2'b01) return c[5:4];
      else if (st == 2'b10) return c[3:2];
      else                 return 2'b11;
   endfunction

   task automatic step(input logic [1:0] st, input logic ac, input logic we, input logic ws,
                       input logic [7:0] wd, input logic rs, input string tag);
      exp_t it;
      logic set_now, clr_now;
      @(negedge clk);
      pwr_state = st; ac_lost = ac; wr_en = we; wr_sel = ws; wr_data = wd; rd_sel = rs;
      it.ctl  = lvl_of(m_cfg, st, ac);
      set_now = (m_prev == 2'b01) && (st == 2'b00);
      clr_now = we && ws && wd[0];
      if (set_now)      m_flag = 1'b1;
      else if (clr_now) m_flag = 1'b0;
      if (we && !ws)    m_cfg = wd[5:0];
      m_prev  = st;
      it.flag = m_flag;
      it.rd   = rs ? {7'b0, m_flag} : {2'b00, m_cfg};
      it.tag  = tag;
      @(posedge clk);
      sb_q.push_back(it);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            check({it.tag, " ctl_n"},       {6'b0, ctl_n},       {6'b0, it.ctl});
            check({it.tag, " resume_flag"}, {7'b0, resume_flag}, {7'b0, it.flag});
            check({it.tag, " rd_data"},     rd_data,             it.rd);
         end
      end
   end

   task automatic run_all();
      // R5: reset state
      #10;
      check("R5 reset ctl_n", {6'b0, ctl_n}, 8'h03);
      check("R5 reset flag", {7'b0, resume_flag}, 8'h00);
      check("R5 reset cfg", rd_data, 8'h0C);
      rd_sel = 1'b1; #1;
      check("R5 reset status", rd_data, 8'h00);
      @(negedge clk); vbat_rst_n = 1'b1; rd_sel = 1'b0;

      step(2'b00, 0, 0, 0, 8'h00, 0, "R4 working");
      step(2'b01, 0, 0, 0, 8'h00, 0, "R1 S3 default");
      step(2'b10, 0, 0, 0, 8'h00, 0, "R2 S5 default");
      step(2'b10, 1, 0, 0, 8'h00, 0, "R3 AC over S5");
      step(2'b00, 0, 1, 0, 8'hFF, 0, "R8 write all ones");
      step(2'b00, 0, 1, 0, 8'h26, 0, "R9 write no same-edge effect");
      step(2'b01, 0, 0, 0, 8'h00, 0, "R1 S3 pattern");
      step(2'b10, 0, 0, 0, 8'h00, 1, "R2 S5 pattern, R6 no set from S3 to S5");
      step(2'b10, 1, 0, 0, 8'h00, 0, "R3 AC over S5 pattern");
      step(2'b01, 1, 0, 0, 8'h00, 0, "R3 AC over S3");
      step(2'b11, 0, 0, 0, 8'h00, 0, "R4 unused code");
      step(2'b01, 0, 0, 0, 8'h00, 1, "R1 enter S3");
      step(2'b00, 0, 0, 0, 8'h00, 1, "R6 return sets flag");
      step(2'b00, 0, 1, 1, 8'h00, 1, "R7 zero write keeps flag");
      step(2'b00, 0, 1, 0, 8'h01, 1, "R7 level write keeps flag");
      step(2'b00, 0, 1, 1, 8'hFE, 1, "R7 bit0 clear keeps flag");
      step(2'b00, 0, 1, 1, 8'h01, 1, "R7 clear");
      step(2'b01, 0, 0, 0, 8'h00, 1, "R1 S3 again");
      step(2'b00, 0, 1, 1, 8'h01, 1, "R7 set wins over clear");
      step(2'b00, 0, 1, 1, 8'h01, 1, "R7 clear again");
      step(2'b10, 0, 1, 0, 8'h3C, 0, "R9 write in S5");
      step(2'b10, 0, 0, 0, 8'h00, 0, "R9 write now visible");
      step(2'b00, 0, 0, 0, 8'h00, 0, "R4 final working");
      @(posedge clk); #3;
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
         end
      join_any
      disable fork;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule